// File: doc/BRIEF.md
# USB Device Endpoint Status Register Block

This block is the register file of a USB device controller. It stores the device address, the per-endpoint enables, the per-endpoint prime bits, and the sticky per-endpoint setup-received and transfer-complete flags. It also holds the port event status flags and drives one interrupt line. Software reaches it through a simple single-cycle register bus: a write strobe, a word address and write data, with combinational read data.

Hardware events arrive as one-cycle pulses on per-endpoint vectors. A bus-reset pulse puts the device back into its default state. It clears the address, disables every endpoint except endpoint 0, cancels all primed transfers and raises a reset-received flag. A separate level input tells software whether the bus reset is still in progress. When that level falls, a port-change flag is raised.

Software cancels outstanding work in two ways. A flush write cancels only the prime bits it selects. A controller reset command returns every register to its power-on value, including the run bit, so the device detaches. Each endpoint vector is 32 bits wide. Bits 15:0 are receive endpoints 0 to 15 and bits 31:16 are transmit endpoints 0 to 15.

Top module: `usb_dev_regs`

## Requirements
- R1: After rst_ni is released, every readable register reads 0, and run_o, irq_o, dev_addr_o, ep_en_o and prime_o are 0.
- R2: The device address register at word offset 3, bits 6:0, is writable and appears on dev_addr_o. A bus_rst_i pulse sets it to 0 on the next clock edge, even if a write happens in the same cycle.
- R3: The endpoint enable register at offset 4 is writable. A bus_rst_i pulse clears every bit except bit 0 and bit 16 (endpoint 0 receive and transmit), and those two keep their values.
- R4: In the prime register at offset 5, writing a 1 sets that bit. A prime_used_i bit clears its prime bit. A bus_rst_i pulse clears all prime bits. A clear wins over a prime write in the same cycle.
- R5: The flush register at offset 6 always reads 0. Writing 1s to it clears exactly the selected prime bits and leaves the others unchanged.
- R6: The setup register at offset 7 and the done register at offset 8 are set by setup_evt_i and done_evt_i. They are write-one-to-clear, so writing back the value just read clears exactly those bits.
- R7: If a hardware set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Status register offset 1, bit 0 (reset-received) is set by bus_rst_i and is write-one-to-clear. irq_o is high while this bit is set and the interrupt enable register at offset 2 has bit 0 set.
- R9: Status bit 1 (port-change) is set the cycle after bus_rst_active_i falls, and is write-one-to-clear. It drives irq_o when enable bit 1 at offset 2 is set.
- R10: Status bit 2 reads the current level of bus_rst_active_i.
- R11: In the command register at offset 0, bit 0 is run and drives run_o. Writing 1 to bit 1 makes bit 1 read 1 for one cycle. On the following edge every register returns to its reset value and bit 1 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset detected |
| bus_rst_active_i | input | 1 | Level: bus reset in progress |
| setup_evt_i | input | 32 | Per-endpoint setup-received pulses |
| done_evt_i | input | 32 | Per-endpoint transfer-complete pulses |
| prime_used_i | input | 32 | Per-endpoint prime-consumed pulses |
| run_o | output | 1 | Run bit; low means detached |
| dev_addr_o | output | 7 | Device address |
| ep_en_o | output | 32 | Endpoint enables |
| prime_o | output | 32 | Primed endpoints |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are same-cycle collisions. One is a hardware set pulse and a software clear landing on the same status bit. Another is a bus reset arriving together with a register write or a prime write. The bench drives the event vectors and the write strobe in the same half cycle and then reads the bit back to see which side won. The controller reset is observed in two steps: the command bit is read in the cycle after the write, and the whole register set is read in the cycle after that.

// File: rtl/usb_regs_pkg.sv
package usb_regs_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_CMD     = 4'd0,
    REG_STS     = 4'd1,
    REG_INTEN   = 4'd2,
    REG_DEVADDR = 4'd3,
    REG_EPEN    = 4'd4,
    REG_PRIME   = 4'd5,
    REG_FLUSH   = 4'd6,
    REG_SETUP   = 4'd7,
    REG_DONE    = 4'd8
  } reg_sel_e;

  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_RST_BIT = 1;
  localparam int STS_RST_BIT = 0;
  localparam int STS_PC_BIT  = 1;
  localparam int STS_ACT_BIT = 2;
  localparam int NUM_FLAGS   = 2;
endpackage

// File: rtl/usb_w1c_bank.sv
module usb_w1c_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [W-1:0] set_i,
  input  logic         w1c_we_i,
  input  logic [W-1:0] w1c_mask_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       bit_q <= 1'b0;
      else if (clr_all_i)                bit_q <= 1'b0;
      else if (set_i[i])                 bit_q <= 1'b1;  // set beats clear
      else if (w1c_we_i && w1c_mask_i[i]) bit_q <= 1'b0;
    end
    assign q_o[i] = bit_q;

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && !clr_all_i) |=> bit_q);
    assert_w1c_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w1c_we_i && w1c_mask_i[i] && !set_i[i]) |=> !bit_q);
  end
endmodule

// File: rtl/usb_prime_ctrl.sv
module usb_prime_ctrl #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic         bus_rst_i,
  input  logic         arm_we_i,
  input  logic [W-1:0] arm_mask_i,
  input  logic         flush_we_i,
  input  logic [W-1:0] flush_mask_i,
  input  logic [W-1:0] used_i,
  output logic [W-1:0] prime_o
);
  logic [W-1:0] prime_q, arm_v, kill_v;

  assign arm_v  = arm_we_i ? arm_mask_i : '0;
  assign kill_v = used_i | (flush_we_i ? flush_mask_i : '0) | {W{bus_rst_i | clr_all_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prime_q <= '0;
    else         prime_q <= (prime_q | arm_v) & ~kill_v;
  end
  assign prime_o = prime_q;

  assert_bus_rst_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (prime_q == '0));

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_flush_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_we_i && flush_mask_i[i]) |=> !prime_q[i]);
    assert_arm_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!prime_q[i] && !(arm_we_i && arm_mask_i[i])) |=> !prime_q[i]);
  end
endmodule

// File: rtl/usb_port_events.sv
module usb_port_events
  import usb_regs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_all_i,
  input  logic                 bus_rst_i,
  input  logic                 bus_rst_active_i,
  input  logic                 sts_we_i,
  input  logic [NUM_FLAGS-1:0] sts_wdata_i,
  input  logic [NUM_FLAGS-1:0] ie_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o
);
  logic                 act_q;
  logic [NUM_FLAGS-1:0] set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q <= 1'b0;
    else if (clr_all_i) act_q <= 1'b0;
    else                act_q <= bus_rst_active_i;
  end

  assign set_v[STS_RST_BIT] = bus_rst_i;
  assign set_v[STS_PC_BIT]  = act_q & ~bus_rst_active_i;

  usb_w1c_bank #(.W(NUM_FLAGS)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (clr_all_i),
    .set_i      (set_v),
    .w1c_we_i   (sts_we_i),
    .w1c_mask_i (sts_wdata_i),
    .q_o        (flags_o)
  );

  assign irq_o = |(flags_o & ie_i);

  assert_rst_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && !clr_all_i) |=> flags_o[STS_RST_BIT]);
  assert_pc_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !bus_rst_active_i && !clr_all_i) |=> flags_o[STS_PC_BIT]);
  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_i == '0) |-> !irq_o);
endmodule

// File: rtl/usb_dev_regs.sv
module usb_dev_regs
  import usb_regs_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int ADDR_W = 7,
  localparam int EPW   = 2 * NUM_EP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [EPW-1:0]    reg_wdata_i,
  output logic [EPW-1:0]    reg_rdata_o,
  input  logic              bus_rst_i,
  input  logic              bus_rst_active_i,
  input  logic [EPW-1:0]    setup_evt_i,
  input  logic [EPW-1:0]    done_evt_i,
  input  logic [EPW-1:0]    prime_used_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [EPW-1:0]    ep_en_o,
  output logic [EPW-1:0]    prime_o,
  output logic              irq_o
);
  localparam logic [EPW-1:0] EP0_MASK = EPW'(1) | (EPW'(1) << NUM_EP);

  logic                 run_q, ctl_rst_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [EPW-1:0]       epen_q;
  logic [NUM_FLAGS-1:0] ie_q, flags;
  logic [EPW-1:0]       setup_q, done_q;
  logic                 clr_all;
  logic we_cmd, we_sts, we_ie, we_addr, we_epen, we_prime, we_flush, we_setup, we_done;

  assign clr_all  = ctl_rst_q;
  assign we_cmd   = reg_we_i && reg_addr_i == REG_CMD;
  assign we_sts   = reg_we_i && reg_addr_i == REG_STS;
  assign we_ie    = reg_we_i && reg_addr_i == REG_INTEN;
  assign we_addr  = reg_we_i && reg_addr_i == REG_DEVADDR;
  assign we_epen  = reg_we_i && reg_addr_i == REG_EPEN;
  assign we_prime = reg_we_i && reg_addr_i == REG_PRIME;
  assign we_flush = reg_we_i && reg_addr_i == REG_FLUSH;
  assign we_setup = reg_we_i && reg_addr_i == REG_SETUP;
  assign we_done  = reg_we_i && reg_addr_i == REG_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      ctl_rst_q <= 1'b0;
    end else if (clr_all) begin
      run_q     <= 1'b0;
      ctl_rst_q <= 1'b0;
    end else if (we_cmd) begin
      run_q     <= reg_wdata_i[CMD_RUN_BIT];
      ctl_rst_q <= reg_wdata_i[CMD_RST_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  addr_q <= '0;
    else if (clr_all || bus_rst_i) addr_q <= '0;
    else if (we_addr)             addr_q <= reg_wdata_i[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        epen_q <= '0;
    else if (clr_all)   epen_q <= '0;
    else if (bus_rst_i) epen_q <= epen_q & EP0_MASK;
    else if (we_epen)   epen_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= '0;
    else if (clr_all) ie_q <= '0;
    else if (we_ie)   ie_q <= reg_wdata_i[NUM_FLAGS-1:0];
  end

  usb_prime_ctrl #(.W(EPW)) u_prime (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_all_i    (clr_all),
    .bus_rst_i    (bus_rst_i),
    .arm_we_i     (we_prime),
    .arm_mask_i   (reg_wdata_i),
    .flush_we_i   (we_flush),
    .flush_mask_i (reg_wdata_i),
    .used_i       (prime_used_i),
    .prime_o      (prime_o)
  );

  usb_w1c_bank #(.W(EPW)) u_setup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (clr_all),
    .set_i      (setup_evt_i),
    .w1c_we_i   (we_setup),
    .w1c_mask_i (reg_wdata_i),
    .q_o        (setup_q)
  );

  usb_w1c_bank #(.W(EPW)) u_done (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (clr_all),
    .set_i      (done_evt_i),
    .w1c_we_i   (we_done),
    .w1c_mask_i (reg_wdata_i),
    .q_o        (done_q)
  );

  usb_port_events u_events (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .clr_all_i        (clr_all),
    .bus_rst_i        (bus_rst_i),
    .bus_rst_active_i (bus_rst_active_i),
    .sts_we_i         (we_sts),
    .sts_wdata_i      (reg_wdata_i[NUM_FLAGS-1:0]),
    .ie_i             (ie_q),
    .flags_o          (flags),
    .irq_o            (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CMD: begin
        reg_rdata_o[CMD_RUN_BIT] = run_q;
        reg_rdata_o[CMD_RST_BIT] = ctl_rst_q;
      end
      REG_STS: begin
        reg_rdata_o[NUM_FLAGS-1:0] = flags;
        reg_rdata_o[STS_ACT_BIT]   = bus_rst_active_i;
      end
      REG_INTEN:   reg_rdata_o[NUM_FLAGS-1:0] = ie_q;
      REG_DEVADDR: reg_rdata_o = EPW'(addr_q);
      REG_EPEN:    reg_rdata_o = epen_q;
      REG_PRIME:   reg_rdata_o = prime_o;
      REG_SETUP:   reg_rdata_o = setup_q;
      REG_DONE:    reg_rdata_o = done_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign run_o      = run_q;
  assign dev_addr_o = addr_q;
  assign ep_en_o    = epen_q;

  assert_addr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (addr_q == '0));
  assert_ep_disable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> ((epen_q & ~EP0_MASK) == '0));
  assert_ep0_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && !clr_all) |=> ((epen_q & EP0_MASK) == $past(epen_q & EP0_MASK)));
  assert_ctl_rst_selfclr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_q |=> (!ctl_rst_q && !run_q && epen_q == '0));
  assert_flush_reads_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_FLUSH) |-> (reg_rdata_o == '0));
endmodule

// File: tb/usb_dev_regs_test.sv
module usb_dev_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bus_rst = 1'b0, bus_act = 1'b0;
  logic [31:0] setup_evt = '0, done_evt = '0, used = '0;
  logic        run;
  logic [6:0]  dev_addr;
  logic [31:0] ep_en, prime;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_dev_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_rst_i(bus_rst),
    .bus_rst_active_i(bus_act), .setup_evt_i(setup_evt), .done_evt_i(done_evt),
    .prime_used_i(used), .run_o(run), .dev_addr_o(dev_addr), .ep_en_o(ep_en),
    .prime_o(prime), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic t_reset_state();
    rd_check("R1 cmd", 4'd0, 0);
    rd_check("R1 sts", 4'd1, 0);
    rd_check("R1 addr", 4'd3, 0);
    rd_check("R1 epen", 4'd4, 0);
    check("R1 outs", {27'd0, run, irq, dev_addr != 0, ep_en != 0, prime != 0}, 0);
  endtask

  task automatic t_bus_reset();
    wr(4'd3, 32'h0000_0055);
    check("R2 addr write", {25'd0, dev_addr}, 32'h55);
    wr(4'd4, 32'hF0F3_00FF);
    wr(4'd5, 32'h0003_0006);
    check("R4 prime armed", prime, 32'h0003_0006);
    pulse_bus_rst();
    check("R2 addr cleared", {25'd0, dev_addr}, 0);
    check("R3 ep0 only", ep_en, 32'h0001_0001);
    check("R4 prime cancelled", prime, 0);
    rd_check("R8 rst flag", 4'd1, 32'h1);
    check("R8 irq masked", {31'd0, irq}, 0);
    wr(4'd2, 32'h1);
    check("R8 irq enabled", {31'd0, irq}, 1);
    wr(4'd1, 32'h1);
    rd_check("R8 rst flag w1c", 4'd1, 0);
    check("R8 irq drops", {31'd0, irq}, 0);
    // collision: write and bus reset together
    @(negedge clk); we = 1'b1; addr = 4'd3; wdata = 32'h7F; bus_rst = 1'b1;
    @(negedge clk); we = 1'b0; bus_rst = 1'b0;
    check("R2 bus reset beats write", {25'd0, dev_addr}, 0);
    wr(4'd4, 32'h0000_0000);
    pulse_bus_rst();
    check("R3 ep0 stays off", ep_en, 0);
    wr(4'd1, 32'h1);
  endtask

  task automatic t_prime_flush();
    wr(4'd5, 32'h8001_0F0F);
    @(negedge clk); used = 32'h0000_0003;
    @(negedge clk); used = 0;
    check("R4 used clears", prime, 32'h8001_0F0C);
    wr(4'd6, 32'h8000_000C);
    check("R5 flush selected", prime, 32'h0001_0F00);
    rd_check("R5 flush reads 0", 4'd6, 0);
    @(negedge clk); we = 1'b1; addr = 4'd5; wdata = 32'h10; used = 32'h10;
    @(negedge clk); we = 1'b0; used = 0;
    check("R4 clear beats arm", prime, 32'h0001_0F00);
    wr(4'd6, 32'hFFFF_FFFF);
    check("R5 flush all", prime, 0);
  endtask

  task automatic t_status_w1c();
    logic [31:0] v;
    @(negedge clk); setup_evt = 32'h0000_0005; done_evt = 32'h0002_0001;
    @(negedge clk); setup_evt = 0; done_evt = 0;
    rd(4'd7, v);
    check("R6 setup set", v, 32'h5);
    @(negedge clk); setup_evt = 32'h0000_0100;
    @(negedge clk); setup_evt = 0;
    wr(4'd7, v);
    rd_check("R6 setup writeback", 4'd7, 32'h100);
    rd(4'd8, v);
    check("R6 done set", v, 32'h0002_0001);
    wr(4'd8, v);
    rd_check("R6 done cleared", 4'd8, 0);
    @(negedge clk); done_evt = 32'h8; we = 1'b1; addr = 4'd8; wdata = 32'h8;
    @(negedge clk); done_evt = 0; we = 1'b0;
    rd_check("R7 set wins", 4'd8, 32'h8);
    wr(4'd8, 32'h8);
    rd_check("R7 later clear", 4'd8, 0);
    wr(4'd7, 32'hFFFF_FFFF);
  endtask

  task automatic t_port_change();
    @(negedge clk); bus_act = 1'b1;
    rd_check("R10 active high", 4'd1, 32'h4);
    @(negedge clk); @(negedge clk);
    rd_check("R9 no flag while active", 4'd1, 32'h4);
    bus_act = 1'b0;
    rd_check("R10 active low", 4'd1, 0);
    @(negedge clk);
    rd_check("R9 pc flag", 4'd1, 32'h2);
    check("R9 irq masked", {31'd0, irq}, 0);
    wr(4'd2, 32'h2);
    check("R9 irq enabled", {31'd0, irq}, 1);
    wr(4'd1, 32'h2);
    rd_check("R9 pc w1c", 4'd1, 0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_ctl_reset();
    wr(4'd0, 32'h1);
    check("R11 run set", {31'd0, run}, 1);
    wr(4'd3, 32'h22);
    wr(4'd4, 32'h0001_0001);
    wr(4'd5, 32'h1);
    wr(4'd2, 32'h3);
    wr(4'd0, 32'h3);
    rd_check("R11 rst bit visible", 4'd0, 32'h3);
    @(negedge clk);
    rd_check("R11 rst self-clears", 4'd0, 0);
    check("R11 run off", {31'd0, run}, 0);
    check("R11 addr", {25'd0, dev_addr}, 0);
    check("R11 ep0 cleared too", ep_en, 0);
    check("R11 prime", prime, 0);
    rd_check("R11 inten", 4'd2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_bus_reset();
    t_prime_flush();
    t_status_w1c();
    t_port_change();
    t_ctl_reset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule